// File: doc/BRIEF.md
# Four-Channel PWM Controller with Boundary-Synchronised Updates

The block generates four independent pulse-width modulated outputs and is programmed through a simple memory-mapped register bus: select, write and read strobes, a byte address, and write and read data. Every channel has a power-of-two clock prescaler, a 16-bit period counter and a polarity bit. The duty value gives how many counts the output stays inactive at the start of each period. The output is active for the remaining counts of the period.

A running channel can be retuned without glitches. Values written to its duty-next or period-next register are held back and copied into the working register only when the current period ends. Each channel sets a bit in the event register whenever it begins a period. Software reads this register, which clears it, to confirm that a queued update has been taken. Enable and disable are write-one-to-act registers. A disable takes effect only at the end of the running period, so the status bit stays set until the channel has actually stopped.

Top module: `pwmq_top`

## Requirements
- R1: After reset every output is low, and the status register, the event register and all channel registers read zero.
- R2: Address map. Global registers: channel-enable at 0x04 (write-only, reads 0), channel-disable at 0x08 (write-only, reads 0), status at 0x0C (bit n = channel n running), event at 0x1C (bit n = channel n began a period). The bank of channel n starts at 0x200 + n*0x20 and holds: mode at +0x00, duty at +0x04, duty-next at +0x08, period at +0x0C, period-next at +0x10. Mode bits: [3:0] prescaler, [9] polarity, [10] update-select (stored and read back). Duty and period registers keep bits [15:0]. Any other offset reads zero and ignores writes.
- R3: A prescaler value p counts the channel once every 2^p clocks. Written values above 10 are stored as 10.
- R4: Every period lasts period*2^p clocks. It starts at the inactive level, stays inactive for min(duty, period)*2^p clocks, and is active for the rest. If duty is at least period, the output is never active.
- R5: With polarity 0 the inactive level is low. With polarity 1 it is high. A channel that is not running drives its inactive level.
- R6: After an enable write, the status bit sets and the first period begins with the counter at zero, exactly 2^p clocks after the write is taken.
- R7: A write to duty-next or period-next while the channel runs changes nothing in the current period. It takes effect from the next period on.
- R8: The event bit of a channel sets each time that channel starts a period, including the first one. A read of 0x1C returns the bits and clears all of them. An event in the same cycle as the read is kept.
- R9: A disable write stops the channel at the end of the period that is running after the write is taken. Until then the status bit stays set.
- R10: While a channel is stopped, writes to duty-next and period-next load the working duty and period at once. Writes to duty and period always load them at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe, qualified by bus_sel; clears the event register when it reads 0x1C |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| pwm_out | output | 4 | Channel outputs, bit n for channel n |

## Verification
On every cycle, the embedded properties check the following:
- a channel stops only on a period-ending tick;
- an idle counter sits at zero;
- a running channel's working duty moves only at a boundary or on a direct write;
- the prescaler stays within 10 and prescaled ticks are spaced correctly;
- the event register keeps new events and empties after a read.

The waveform itself can only be shown by the bench's scenarios. These cover:
- inactive-run length and active count over whole periods, across prescaler, period, duty and polarity;
- the exact enable latency and disable latency;
- queued updates that leave the running period intact and change the following ones.

// File: rtl/pwmq_pkg.sv
`timescale 1ns/1ps
package pwmq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int CNT_W    = 16;
  localparam int PRES_W   = 4;
  localparam int PRES_MAX = 10;
  localparam int DIV_W    = PRES_MAX;
  localparam int OFF_W    = 5;

  localparam logic [ADDR_W-1:0] ADR_CH_ENA  = 12'h004;
  localparam logic [ADDR_W-1:0] ADR_CH_DIS  = 12'h008;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 12'h00C;
  localparam logic [ADDR_W-1:0] ADR_EVENT   = 12'h01C;
  localparam logic [ADDR_W-1:0] BANK_BASE   = 12'h200;
  localparam int                BANK_STRIDE = 1 << OFF_W;

  localparam logic [OFF_W-1:0] OFF_MODE     = 5'h00;
  localparam logic [OFF_W-1:0] OFF_DUTY     = 5'h04;
  localparam logic [OFF_W-1:0] OFF_DUTY_NXT = 5'h08;
  localparam logic [OFF_W-1:0] OFF_PER      = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_PER_NXT  = 5'h10;

  localparam int MODE_POL_BIT = 9;
  localparam int MODE_SEL_BIT = 10;

  // Saturate a prescaler request at the largest legal value.
  function automatic logic [PRES_W-1:0] pwmq_clamp_pres(input logic [PRES_W-1:0] p);
    return (p > PRES_W'(PRES_MAX)) ? PRES_W'(PRES_MAX) : p;
  endfunction

  // Divider terminal count: 2^p - 1.
  function automatic logic [DIV_W-1:0] pwmq_div_limit(input logic [PRES_W-1:0] p);
    logic [DIV_W:0] w;
    w = ((DIV_W+1)'(1) << p) - (DIV_W+1)'(1);
    return w[DIV_W-1:0];
  endfunction

  // True on the last count of a period (period 0 behaves as 1).
  function automatic logic pwmq_is_last(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] per);
    return ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, per};
  endfunction

  // Active phase once the inactive (duty) counts have elapsed.
  function automatic logic pwmq_is_active(input logic [CNT_W-1:0] cnt,
                                          input logic [CNT_W-1:0] duty);
    return cnt >= duty;
  endfunction
endpackage

// File: rtl/pwmq_tick.sv
`timescale 1ns/1ps
module pwmq_tick
  import pwmq_pkg::*;
#(
  parameter int P_W = PRES_W,
  parameter int D_W = DIV_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active_i,
  input  logic [P_W-1:0] pres_i,
  output logic           tick_o
);
  logic [D_W-1:0] div_q;
  logic [D_W-1:0] lim;

  assign lim    = pwmq_div_limit(pres_i);
  assign tick_o = active_i && (div_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (!active_i || tick_o) div_q <= '0;
    else                        div_q <= div_q + D_W'(1);
  end

  // R3: after a tick the divider restarts, so a tick can only follow if the limit is zero
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || lim == '0));
endmodule

// File: rtl/pwmq_chan.sv
`timescale 1ns/1ps
module pwmq_chan
  import pwmq_pkg::*;
#(
  parameter int C_W = CNT_W,
  parameter int P_W = PRES_W,
  parameter int D_W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [C_W-1:0]   wdata_i,
  input  logic             en_i,
  input  logic             dis_i,
  output logic [D_W-1:0]   rdata_o,
  output logic             run_o,
  output logic             start_o,
  output logic             pwm_o
);
  logic [P_W-1:0] pres_q;
  logic           pol_q, sel_q;
  logic [C_W-1:0] duty_q, per_q, duty_nxt_q, per_nxt_q;
  logic           duty_pend_q, per_pend_q;
  logic           run_q, start_q, stop_q;
  logic           run_d, start_d, stop_d;
  logic [C_W-1:0] cnt_q, cnt_d;
  logic           tick, last, bnd;

  pwmq_tick #(.P_W(P_W), .D_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .active_i(start_q | run_q),
    .pres_i(pres_q), .tick_o(tick)
  );

  assign last    = pwmq_is_last(cnt_q, per_q);
  assign bnd     = tick && run_q && last;
  assign start_o = tick && (start_q || (run_q && last && !stop_q));
  assign run_o   = run_q;
  assign pwm_o   = pol_q ^ (run_q && pwmq_is_active(cnt_q, duty_q));

  always_comb begin
    run_d = run_q; start_d = start_q; stop_d = stop_q; cnt_d = cnt_q;
    if (tick) begin
      if (start_q) begin
        run_d = 1'b1; start_d = 1'b0; cnt_d = '0;
      end else if (run_q) begin
        if (last) begin
          cnt_d = '0;
          if (stop_q) begin run_d = 1'b0; stop_d = 1'b0; end
        end else begin
          cnt_d = cnt_q + C_W'(1);
        end
      end
    end
    if (en_i) begin
      stop_d = 1'b0;
      if (!run_d) start_d = 1'b1;
    end
    if (dis_i) begin
      start_d = 1'b0;
      if (run_d) stop_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0; cnt_q <= '0;
    end else begin
      run_q <= run_d; start_q <= start_d; stop_q <= stop_d; cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0; pol_q <= 1'b0; sel_q <= 1'b0;
      duty_q <= '0; per_q <= '0; duty_nxt_q <= '0; per_nxt_q <= '0;
      duty_pend_q <= 1'b0; per_pend_q <= 1'b0;
    end else begin
      if (bnd && duty_pend_q) begin duty_q <= duty_nxt_q; duty_pend_q <= 1'b0; end
      if (bnd && per_pend_q)  begin per_q  <= per_nxt_q;  per_pend_q  <= 1'b0; end
      if (wr_i) begin
        case (off_i)
          OFF_MODE: begin
            pres_q <= pwmq_clamp_pres(wdata_i[P_W-1:0]);
            pol_q  <= wdata_i[MODE_POL_BIT];
            sel_q  <= wdata_i[MODE_SEL_BIT];
          end
          OFF_DUTY: duty_q <= wdata_i;
          OFF_PER:  per_q  <= wdata_i;
          OFF_DUTY_NXT: begin
            duty_nxt_q <= wdata_i;
            if (run_q) duty_pend_q <= 1'b1;
            else       duty_q      <= wdata_i;
          end
          OFF_PER_NXT: begin
            per_nxt_q <= wdata_i;
            if (run_q) per_pend_q <= 1'b1;
            else       per_q      <= wdata_i;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_MODE: begin
        rdata_o[P_W-1:0]      = pres_q;
        rdata_o[MODE_POL_BIT] = pol_q;
        rdata_o[MODE_SEL_BIT] = sel_q;
      end
      OFF_DUTY:     rdata_o[C_W-1:0] = duty_q;
      OFF_DUTY_NXT: rdata_o[C_W-1:0] = duty_nxt_q;
      OFF_PER:      rdata_o[C_W-1:0] = per_q;
      OFF_PER_NXT:  rdata_o[C_W-1:0] = per_nxt_q;
      default: ;
    endcase
  end

  // R9: a channel stops only on a tick that ends a period
  a_r9_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(bnd));
  // R6: an idle channel holds its counter at zero
  a_r6_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));
  // R7: working duty of a running channel moves only at a boundary or on a direct write
  a_r7_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !bnd && !(wr_i && off_i == OFF_DUTY)) |=> $stable(duty_q));
  // R3: stored prescaler never exceeds the legal maximum
  a_r3_pres_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pres_q <= P_W'(PRES_MAX));
endmodule

// File: rtl/pwmq_top.sv
`timescale 1ns/1ps
module pwmq_top
  import pwmq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int IDX_W = $clog2(NCH);
  localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(NCH * BANK_STRIDE);

  logic [ADDR_W-1:0] bank_rel;
  logic              bank_hit;
  logic [IDX_W-1:0]  bank_idx;
  logic              wr_any, ena_wr, dis_wr, evt_rd;
  logic [NCH-1:0]    run_v, start_v, isr_q;
  logic [DATA_W-1:0] ch_rdata [NCH];
  logic              unused_wdata_hi;

  assign bank_rel = bus_addr - BANK_BASE;
  assign bank_hit = (bus_addr >= BANK_BASE) && (bank_rel < BANK_SPAN);
  assign bank_idx = bank_rel[OFF_W +: IDX_W];
  assign wr_any   = bus_sel && bus_wr;
  assign ena_wr   = wr_any && (bus_addr == ADR_CH_ENA);
  assign dis_wr   = wr_any && (bus_addr == ADR_CH_DIS);
  assign evt_rd   = bus_sel && bus_rd && (bus_addr == ADR_EVENT);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmq_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_any && bank_hit && (bank_idx == IDX_W'(g))),
      .off_i(bank_rel[OFF_W-1:0]),
      .wdata_i(bus_wdata[CNT_W-1:0]),
      .en_i(ena_wr && bus_wdata[g]),
      .dis_i(dis_wr && bus_wdata[g]),
      .rdata_o(ch_rdata[g]),
      .run_o(run_v[g]),
      .start_o(start_v[g]),
      .pwm_o(pwm_out[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (evt_rd ? '0 : isr_q) | start_v;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == ADR_STATUS)     bus_rdata[NCH-1:0] = run_v;
      else if (bus_addr == ADR_EVENT) bus_rdata[NCH-1:0] = isr_q;
      else if (bank_hit)              bus_rdata = ch_rdata[bank_idx];
    end
  end

  // R8: a period start is never lost, even when it meets a clearing read
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_v != '0) |=> ((isr_q & $past(start_v)) == $past(start_v)));
  // R8: a clearing read with no new period start empties the register
  a_r8_event_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && start_v == '0) |=> (isr_q == '0));
endmodule

// File: tb/test_pwmq_top.sv
`timescale 1ns/1ps
module test_pwmq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwmq_top i_pwmq_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [11:0] bank(input int ch, input int off);
    return 12'(32'h200 + ch * 32'h20 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  // Poll the status register once per clock; polls = cycles seen before the wanted value.
  task automatic wait_status(input int ch, input logic want, input int limit, output int polls);
    polls = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 12'h00C;
      #1;
      if (bus_rdata[ch] === want) break;
      polls++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int per_tab [3];
    int dut_tab [4];
    int polls;
    per_tab = '{1, 4, 7};
    dut_tab = '{0, 1, 3, 9};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1 chk("R1 outputs", {28'b0, pwm_out}, 32'h0);
    bus_read(12'h00C, v); chk("R1 status", v, 32'h0);
    bus_read(12'h01C, v); chk("R1 event", v, 32'h0);
    bus_read(bank(2, 0), v); chk("R1 mode", v, 32'h0);

    // R2: readback, field positions, unmapped offsets
    bus_write(bank(3, 0), 32'h0000_0605);
    bus_read(bank(3, 0), v); chk("R2 mode readback", v, 32'h605);
    bus_write(bank(0, 4), 32'h0001_2345);
    bus_read(bank(0, 4), v); chk("R2 duty 16 bits", v, 32'h2345);
    bus_write(bank(1, 12'h14), 32'h55);
    bus_read(bank(1, 12'h14), v); chk("R2 unmapped bank offset", v, 32'h0);
    bus_write(12'h280, 32'h77);
    bus_read(12'h280, v); chk("R2 beyond last bank", v, 32'h0);
    bus_read(12'h004, v); chk("R2 enable reads zero", v, 32'h0);
    bus_read(12'h010, v); chk("R2 unmapped global", v, 32'h0);
    // R3: prescaler saturation
    bus_write(bank(2, 0), 32'h0000_000F);
    bus_read(bank(2, 0), v); chk("R3 prescaler clamp", v, 32'hA);

    // Sweep: channel, prescaler, period, duty, polarity
    for (int ch = 0; ch < 4; ch++)
      for (int p = 0; p < 3; p++)
        for (int pi = 0; pi < 3; pi++)
          for (int di = 0; di < 4; di++) begin
            int P, d, L, mind, exp_first, exp_act, first, act;
            logic pol, o;
            P = per_tab[pi]; d = dut_tab[di];
            pol = 1'((ch + di + p) % 2);
            L = P << p;
            mind = (d < P) ? d : P;
            exp_first = (d < P) ? (mind << p) : -1;
            exp_act = 2 * ((P - mind) << p);
            bus_write(bank(ch, 0), (32'(pol) << 9) | (32'(ch % 2) << 10) | 32'(p));
            if (ch % 2 == 1) begin
              bus_write(bank(ch, 8), 32'(d));
              bus_write(bank(ch, 12'h10), 32'(P));
              bus_read(bank(ch, 4), v);
              chk("R10 duty-next while stopped", v, 32'(d));
              bus_read(bank(ch, 12'hC), v);
              chk("R10 period-next while stopped", v, 32'(P));
            end else begin
              bus_write(bank(ch, 4), 32'(d));
              bus_write(bank(ch, 12'hC), 32'(P));
            end
            @(negedge clk); #1;
            chk("R5 idle level", 32'(pwm_out[ch]), 32'(pol));
            bus_write(12'h004, 32'(1) << ch);
            wait_status(ch, 1'b1, 2000, polls);
            chk("R6 enable latency", 32'(polls), 32'(1) << p);
            first = -1; act = 0;
            for (int i = 0; i < 2 * L; i++) begin
              if (i > 0) begin @(negedge clk); #1; end
              o = pwm_out[ch];
              if (o !== pol) begin
                act++;
                if (first < 0) first = i;
              end
            end
            chk("R4 inactive run at period start", 32'(first), 32'(exp_first));
            chk("R4 R5 active clocks in two periods", 32'(act), 32'(exp_act));
            bus_write(12'h008, 32'(1) << ch);
            wait_status(ch, 1'b0, 2000, polls);
            chk("R9 disable latency", 32'(polls), (L == 1) ? 32'd1 : 32'(L - 1));
            #1 chk("R5 level after stop", 32'(pwm_out[ch]), 32'(pol));
          end

    // R7: queued duty and period updates on a running channel
    begin
      int c1, c2, c3;
      logic o;
      bus_write(bank(1, 0), 32'h0);
      bus_write(bank(1, 4), 32'd4);
      bus_write(bank(1, 12'hC), 32'd10);
      bus_write(12'h004, 32'h2);
      wait_status(1, 1'b1, 100, polls);
      c1 = 0; c2 = 0; c3 = 0;
      for (int i = 0; i < 36; i++) begin
        if (i > 0) begin @(negedge clk); #1; end
        bus_wr = 1'b0; bus_sel = 1'b0;
        o = pwm_out[1];
        if (o === 1'b1) begin
          if (i < 10) c1++;
          else if (i < 20) c2++;
          else c3++;
        end
        if (i == 3) begin
          bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = bank(1, 8); bus_wdata = 32'd7;
        end
        if (i == 13) begin
          bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = bank(1, 12'h10); bus_wdata = 32'd16;
        end
      end
      chk("R7 current period unchanged", 32'(c1), 32'd6);
      chk("R7 new duty next period", 32'(c2), 32'd3);
      chk("R7 new period and duty", 32'(c3), 32'd9);
      bus_read(bank(1, 4), v); chk("R7 working duty loaded", v, 32'd7);
      bus_write(12'h008, 32'h2);
      wait_status(1, 1'b0, 100, polls);
    end

    // R8: event flags and clear-on-read
    bus_read(12'h01C, v);
    bus_write(bank(2, 0), 32'h0);
    bus_write(bank(2, 4), 32'd10);
    bus_write(bank(2, 12'hC), 32'd50);
    bus_write(12'h004, 32'h4);
    wait_status(2, 1'b1, 100, polls);
    bus_read(12'h01C, v); chk("R8 first period start flagged", v, 32'h4);
    bus_read(12'h01C, v); chk("R8 read clears", v, 32'h0);
    repeat (60) @(negedge clk);
    bus_read(12'h01C, v); chk("R8 next period start flagged", v, 32'h4);
    bus_write(12'h008, 32'h4);
    wait_status(2, 1'b0, 100, polls);
    bus_read(12'h00C, v); chk("R9 all stopped", v, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule